// File: doc/BRIEF.md
# Fault Input Conditioning Filter

This block cleans up one raw fault line of a PWM timer before that line reaches the fault-action logic. The raw input first passes a two-flop synchronizer. It then runs through three stages, and each stage can be switched on alone or together with the others. A glitch filter drops pulses that are shorter than a programmed number of cycles. A blanking timer masks the fault for a programmed time after a chosen edge of the associated PWM output. A qualification gate lets the fault through only while that output sits at its active (high) level.

All pins are plain level signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The configuration inputs are expected to be static while a fault is being watched. The conditioned fault leaves on one registered output. With the filter length at zero and the other two stages off, that output is the synchronized input delayed by one more flop.

Top module: `fault_cond_filter`

## Requirements
- R1: During reset, and on the first two clock edges after reset is released, `fault_o` is 0. After release, blanking does not start unless the PWM level actually changes after reset.
- R2: With `flt_len_i` = 0, blanking off and qualification off, a raw pulse that is high before edge 1 and lasts L cycles drives `fault_o` high on edges 3 through L+2.
- R3: With `flt_len_i` = N > 0, a raw pulse shorter than N cycles never shows on `fault_o`.
- R4: With `flt_len_i` = N > 0, a raw pulse of L >= N cycles drives `fault_o` high on edges 3+N through L+3, which is L-N+1 cycles. Its rise is delayed by N cycles.
- R5: `blank_edge_i` selects the triggering PWM edge: 0 none, 1 rising, 2 falling, 3 either. An edge of the other polarity starts no blanking.
- R6: When a selected edge occurs before edge 1 and `blank_len_i` = B > 0 (prescale off), `fault_o` is held at 0 on edges 1 through B+1. A value of B = 0 blanks nothing.
- R7: With `blank_div_i` = 1, the blanking count steps once every 64 clocks, so `fault_o` is held at 0 on edges 1 through 64*B+1.
- R8: A selected edge that arrives while a blanking window is still open reloads the count. With the second edge before edge g+1, masking lasts through edge g+B+1.
- R9: With `qual_en_i` = 1, `fault_o` is 0 on any edge that follows a cycle in which `pwm_level_i` is 0. With `qual_en_i` = 0, the PWM level has no effect.
- R10: The three stages combine: `fault_o` is high only where every enabled stage lets the fault through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_raw_i | input | 1 | Raw fault line, asynchronous to clk |
| pwm_level_i | input | 1 | Level of the associated PWM output, 1 = active |
| flt_len_i | input | FLT_W | Glitch filter length in cycles, 0 = bypass |
| blank_edge_i | input | 2 | Blanking trigger edge: 0 none, 1 rise, 2 fall, 3 both |
| blank_len_i | input | BLANK_W | Blanking length in counter steps |
| blank_div_i | input | 1 | 1 = blanking counter steps every 64 clocks |
| qual_en_i | input | 1 | 1 = pass faults only while PWM level is 1 |
| fault_o | output | 1 | Conditioned fault |

## Verification
The hardest case to reach is a blanking window that gets reopened before it has closed. This needs two selected PWM edges at a chosen spacing while the fault is held asserted, so that the count of masked cycles shows whether the count was reloaded or left to run out. The bench holds the raw fault high and toggles the PWM level twice in either-edge mode, once inside the window and once after it. It then compares the total of masked cycles against gap + length + 1 and against two separate windows of length + 1. The glitch filter is swept over every pulse width from 1 to 8 against lengths 0 to 6, and the expected rise index and width are computed arithmetically.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  typedef enum logic [1:0] {
    BLK_OFF  = 2'd0,
    BLK_RISE = 2'd1,
    BLK_FALL = 2'd2,
    BLK_BOTH = 2'd3
  } blank_edge_e;
endpackage

// File: rtl/fcf_sync.sv
module fcf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) begin
        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fcf_glitch.sv
module fcf_glitch #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             pass_o
);
  logic [CNT_W-1:0] run_q;
  logic             bypass;

  assign bypass = (len_i == '0);

  // run length of the high level, saturating at the programmed length
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!level_i) begin
      run_q <= '0;
    end else if (run_q < len_i) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= len_i;
    end
  end

  assign pass_o = bypass ? level_i : (run_q == len_i);
endmodule

// File: rtl/fcf_blank.sv
module fcf_blank #(
  parameter int LEN_W    = 8,
  parameter int PRESCALE = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwm_i,
  input  fcf_pkg::blank_edge_e mode_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 div_en_i,
  output logic                 blank_o
);
  import fcf_pkg::*;

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic             pwm_d;
  logic             rise, fall, hit, load, tick, active;
  logic [LEN_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;

  assign rise = pwm_i & ~pwm_d;
  assign fall = ~pwm_i & pwm_d;

  always_comb begin
    unique case (mode_i)
      BLK_RISE: hit = rise;
      BLK_FALL: hit = fall;
      BLK_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

  assign load   = hit && (len_i != '0);
  assign active = (cnt_q != '0);
  assign tick   = !div_en_i || (pre_q == PRE_LAST);

  // previous level follows the pin even in reset, so no false edge at release
  always_ff @(posedge clk) begin
    pwm_d <= pwm_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (load) begin
      cnt_q <= len_i;
      pre_q <= '0;
    end else if (active) begin
      if (tick) begin
        cnt_q <= cnt_q - 1'b1;
        pre_q <= '0;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign blank_o = load || active;
endmodule

// File: rtl/fault_cond_filter.sv
module fault_cond_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_W       = 4,
  parameter int BLANK_W     = 8,
  parameter int BLANK_DIV   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_raw_i,
  input  logic               pwm_level_i,
  input  logic [FLT_W-1:0]   flt_len_i,
  input  logic [1:0]         blank_edge_i,
  input  logic [BLANK_W-1:0] blank_len_i,
  input  logic               blank_div_i,
  input  logic               qual_en_i,
  output logic               fault_o
);
  import fcf_pkg::*;

  logic fault_sync;
  logic fault_filt;
  logic blanked;
  logic qual_ok;

  fcf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (fault_raw_i),
    .q_o   (fault_sync)
  );

  fcf_glitch #(.CNT_W(FLT_W)) u_glitch (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (fault_sync),
    .len_i   (flt_len_i),
    .pass_o  (fault_filt)
  );

  fcf_blank #(.LEN_W(BLANK_W), .PRESCALE(BLANK_DIV)) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_i    (pwm_level_i),
    .mode_i   (blank_edge_e'(blank_edge_i)),
    .len_i    (blank_len_i),
    .div_en_i (blank_div_i),
    .blank_o  (blanked)
  );

  assign qual_ok = !qual_en_i || pwm_level_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_o <= 1'b0;
    end else begin
      fault_o <= fault_filt && !blanked && qual_ok;
    end
  end
endmodule

// File: rtl/fault_cond_filter_chk.sv
module fault_cond_filter_chk #(
  parameter int BLANK_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fault_raw_i,
  input logic               pwm_level_i,
  input logic [1:0]         blank_edge_i,
  input logic [BLANK_W-1:0] blank_len_i,
  input logic               qual_en_i,
  input logic               fault_o,
  input logic [BLANK_W-1:0] blank_cnt,
  input logic               blank_hit
);
  // R2: no raw activity over the pipeline depth means no output
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fault_raw_i, 2) && !$past(fault_raw_i, 3) &&
     !$past(fault_raw_i, 4) && !$past(fault_raw_i, 5)) |-> !fault_o);

  // R5: a selected rising edge masks the next output
  p_blank_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((blank_edge_i == 2'd1 || blank_edge_i == 2'd3) && $rose(pwm_level_i) &&
     blank_len_i != '0) |=> !fault_o);

  // R5: a selected falling edge masks the next output
  p_blank_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((blank_edge_i == 2'd2 || blank_edge_i == 2'd3) && $fell(pwm_level_i) &&
     blank_len_i != '0) |=> !fault_o);

  // R7: without a reload the blanking count drops by at most one per clock
  p_blank_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_cnt != '0 && !blank_hit) |=>
      (blank_cnt == $past(blank_cnt) ||
       blank_cnt == BLANK_W'($past(blank_cnt) - 1'b1)));

  // R9: inactive PWM level with qualification on blocks the output
  p_qual_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_en_i && !pwm_level_i) |=> !fault_o);
endmodule

bind fault_cond_filter fault_cond_filter_chk #(.BLANK_W(BLANK_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fault_raw_i  (fault_raw_i),
  .pwm_level_i  (pwm_level_i),
  .blank_edge_i (blank_edge_i),
  .blank_len_i  (blank_len_i),
  .qual_en_i    (qual_en_i),
  .fault_o      (fault_o),
  .blank_cnt    (u_blank.cnt_q),
  .blank_hit    (u_blank.hit)
);

// File: tb/fault_cond_filter_bench.sv
`timescale 1ns/1ps
module fault_cond_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fault_raw_i;
  logic       pwm_level_i;
  logic [3:0] flt_len_i;
  logic [1:0] blank_edge_i;
  logic [7:0] blank_len_i;
  logic       blank_div_i;
  logic       qual_en_i;
  logic       fault_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fault_cond_filter u_fault_cond_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_raw_i  (fault_raw_i),
    .pwm_level_i  (pwm_level_i),
    .flt_len_i    (flt_len_i),
    .blank_edge_i (blank_edge_i),
    .blank_len_i  (blank_len_i),
    .blank_div_i  (blank_div_i),
    .qual_en_i    (qual_en_i),
    .fault_o      (fault_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // blanking run: fault held high, PWM toggled at step 0 and optionally at step gap
  task automatic run_blank(input string tag, input logic [1:0] mode, input logic start,
                           input int len, input logic div, input int gap, input int exp_low);
    int low;
    int win;
    low = 0;
    flt_len_i    = 4'd0;
    qual_en_i    = 1'b0;
    blank_edge_i = 2'd0;
    fault_raw_i  = 1'b1;
    pwm_level_i  = start;
    repeat (6) tick();
    blank_edge_i = mode;
    blank_len_i  = 8'(len);
    blank_div_i  = div;
    tick();
    win = (div ? 64 * len : len) + ((gap > 0) ? gap : 0) + 40;
    for (int i = 0; i < win; i++) begin
      if (i == 0)   pwm_level_i = ~start;
      if (i == gap) pwm_level_i = start;
      tick();
      if (!fault_o) low++;
    end
    check_eq(tag, low, exp_low);
    blank_edge_i = 2'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state with fault and PWM already high
    rst_n        = 1'b0;
    fault_raw_i  = 1'b1;
    pwm_level_i  = 1'b1;
    flt_len_i    = 4'd0;
    blank_edge_i = 2'd1;
    blank_len_i  = 8'd20;
    blank_div_i  = 1'b0;
    qual_en_i    = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check_eq("R1 in reset", int'(fault_o), 0);
    end
    rst_n = 1'b1;
    for (int s = 1; s <= 3; s++) begin
      tick();
      check_eq("R1 after release", int'(fault_o), (s >= 3) ? 1 : 0);
    end

    // R2 R3 R4: filter length against pulse width sweep
    blank_edge_i = 2'd0;
    for (int n = 0; n <= 6; n++) begin
      for (int l = 1; l <= 8; l++) begin
        int first;
        int cnt;
        int exp_cnt;
        int exp_first;
        string tag;
        flt_len_i   = 4'(n);
        fault_raw_i = 1'b0;
        repeat (8) tick();
        first = -1;
        cnt   = 0;
        for (int i = 0; i < l + n + 10; i++) begin
          fault_raw_i = (i < l);
          tick();
          if (fault_o) begin
            cnt++;
            if (first < 0) first = i + 1;
          end
        end
        exp_cnt   = (n == 0) ? l : ((l >= n) ? l - n + 1 : 0);
        exp_first = (exp_cnt == 0) ? -1 : ((n == 0) ? 3 : 3 + n);
        tag = (n == 0) ? "R2" : ((l < n) ? "R3" : "R4");
        check_eq({tag, " width"}, cnt, exp_cnt);
        check_eq({tag, " first edge"}, first, exp_first);
      end
    end

    // R6: window length by programmed count
    run_blank("R6 len0",   2'd1, 1'b0, 0,   1'b0, -1, 0);
    run_blank("R6 len1",   2'd1, 1'b0, 1,   1'b0, -1, 2);
    run_blank("R6 len2",   2'd1, 1'b0, 2,   1'b0, -1, 3);
    run_blank("R6 len5",   2'd1, 1'b0, 5,   1'b0, -1, 6);
    run_blank("R6 len17",  2'd1, 1'b0, 17,  1'b0, -1, 18);
    run_blank("R6 len255", 2'd1, 1'b0, 255, 1'b0, -1, 256);
    // R5: edge selection
    run_blank("R5 rise mode fall edge", 2'd1, 1'b1, 5, 1'b0, -1, 0);
    run_blank("R5 fall mode fall edge", 2'd2, 1'b1, 5, 1'b0, -1, 6);
    run_blank("R5 fall mode rise edge", 2'd2, 1'b0, 5, 1'b0, -1, 0);
    run_blank("R5 both mode rise",      2'd3, 1'b0, 4, 1'b0, -1, 5);
    run_blank("R5 both mode fall",      2'd3, 1'b1, 4, 1'b0, -1, 5);
    run_blank("R5 off mode",            2'd0, 1'b0, 9, 1'b0, -1, 0);
    // R7: prescaled blanking
    run_blank("R7 div len1", 2'd1, 1'b0, 1, 1'b1, -1, 65);
    run_blank("R7 div len3", 2'd1, 1'b0, 3, 1'b1, -1, 193);
    run_blank("R7 div len0", 2'd1, 1'b0, 0, 1'b1, -1, 0);
    // R8: reload inside the window, then a second edge after it closed
    run_blank("R8 reload",  2'd3, 1'b0, 10, 1'b0, 4, 15);
    run_blank("R8 separate", 2'd3, 1'b0, 3, 1'b0, 7, 8);

    // R9: qualification follows the PWM level one edge later
    flt_len_i    = 4'd0;
    blank_edge_i = 2'd0;
    fault_raw_i  = 1'b1;
    pwm_level_i  = 1'b1;
    qual_en_i    = 1'b1;
    repeat (6) tick();
    for (int i = 0; i < 48; i++) begin
      logic p;
      p = ((i % 3) == 0) || ((i % 7) == 1) || ((i % 11) > 7);
      pwm_level_i = p;
      tick();
      check_eq("R9 qual on", int'(fault_o), int'(p));
    end
    qual_en_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pwm_level_i = i[1];
      tick();
      if (i > 0) check_eq("R9 qual off", int'(fault_o), 1);
    end

    // R10: filter 2, rising-edge blanking 6, qualification on
    flt_len_i    = 4'd2;
    blank_len_i  = 8'd6;
    blank_div_i  = 1'b0;
    qual_en_i    = 1'b1;
    blank_edge_i = 2'd0;
    fault_raw_i  = 1'b0;
    pwm_level_i  = 1'b0;
    repeat (8) tick();
    blank_edge_i = 2'd1;
    tick();
    for (int i = 0; i < 20; i++) begin
      int s;
      s = i + 1;
      pwm_level_i = (i < 12);
      fault_raw_i = 1'b1;
      tick();
      check_eq("R10 combined", int'(fault_o), (s >= 8 && s <= 12) ? 1 : 0);
    end

    summary();
    $finish;
  end
endmodule